// File: doc/BRIEF.md
# Power-of-two Montgomery reducer

This block takes one unsigned operand `y` and returns `y · 2^-k mod m`, where the odd modulus `m` and the shift count `k` are fixed by parameters. Multiplying by the modular inverse of `2^k` is the decryption-side step of a knapsack scheme whose secret multiplier is a power of two. It is also a generic way to strip a Montgomery factor.

The block has no multiplier. An accumulator is loaded with `y`. It then runs `k` iterations. In each one an odd value first has `m` added and is then halved, and an even value is simply halved. A single conditional subtraction of `m` follows, so the result lies in `[0, m)`.

A one-cycle `start_i` pulse launches an operation. `ready_o` rises once the result is on `result_o`. Both then hold until the next accepted start. Chained stages can connect one stage's ready to the next stage's start.

Top module: `mont_pow2_reducer`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first start, `ready_o` is 0 and `result_o` is 0.
- R2: When `ready_o` is high, `result_o` equals `(y · inv) mod m`. Here `inv` is the unique value in `[1, m)` with `(inv · 2^k) mod m = 1`. This holds for any `y < 2^DATA_W` with `y < m · 2^k`. With the defaults (m = 4093, k = 9) the inverse is 1367.
- R3: The accumulator never needs more than `max(DATA_W, width of m)` bits. The extra carry bit kept above the operand width is never set after an add-then-halve iteration, including for `y = 2^DATA_W - 1`.
- R4: If `start_i` is high at rising edge n while the block is idle or ready, then `ready_o` is 0 after edges n through n+k. It is 1 after edge n+k+1. Exactly `k` halving iterations and one correction cycle take place.
- R5: Once high, `ready_o` stays high and `result_o` keeps its value for as long as `start_i` stays low, whatever `y_i` does.
- R6: A `start_i` pulse that arrives while an operation is in progress is ignored. The result and the latency of the running operation are unchanged.
- R7: A `start_i` pulse while `ready_o` is high begins a new operation. `ready_o` is 0 after that edge.
- R8: An input that is a multiple of `m` (including 0 and `m` itself) gives the result 0. An input of `2^k` gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation on `y_i` (accepted when idle or ready) |
| y_i | input | DATA_W | Operand, sampled on the accepting edge |
| result_o | output | RES_W | Reduced result `y · 2^-k mod m` |
| ready_o | output | 1 | Result valid; held until the next accepted start |

## Verification
The assertions assume three things: `m` is odd, every operand fits in `DATA_W` bits, and every operand stays below `m · 2^k`. Under these conditions the accumulator keeps its top bit clear and one final subtraction gives a fully reduced value. The default parameters make `2^DATA_W` smaller than `m · 2^k`, so random operands drawn from `$urandom` masked to 16 bits always meet the precondition. The directed cases target the edges of that range: all-ones, zero, exact multiples of `m`, and `2^k`.

// File: rtl/mont_red_pkg.sv
package mont_red_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } red_state_e;
endpackage

// File: rtl/mont_halve_step.sv
module mont_halve_step #(
  parameter int ACC_W   = 17,
  parameter int MODULUS = 4093
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W:0] MOD_X = (ACC_W+1)'(MODULUS);

  logic [ACC_W:0] sum;

  // odd values take m first so the halving is exact
  always_comb begin
    sum   = {1'b0, acc_i} + (acc_i[0] ? MOD_X : '0);
    acc_o = ACC_W'(sum >> 1);
  end
endmodule

// File: rtl/mont_final_sub.sv
module mont_final_sub #(
  parameter int ACC_W   = 17,
  parameter int RES_W   = 12,
  parameter int MODULUS = 4093
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] res_o
);
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(MODULUS);

  logic             ge_mod;
  logic [ACC_W-1:0] diff;

  always_comb begin
    ge_mod = (acc_i >= MOD_V);
    diff   = acc_i - MOD_V;
    res_o  = RES_W'(ge_mod ? diff : acc_i);
  end
endmodule

// File: rtl/mont_seq_ctrl.sv
module mont_seq_ctrl
  import mont_red_pkg::*;
#(
  parameter int SHIFT_K = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(SHIFT_K + 1);
  localparam logic [CNT_W-1:0] K_V = CNT_W'(SHIFT_K);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  red_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  always_comb begin
    accept  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fix_o   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          load_o  = 1'b1;
          cnt_d   = K_V;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q - ONE;
        if (cnt_q == ONE) state_d = ST_FIX;
      end
      ST_FIX: begin
        fix_o   = 1'b1;
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o = (state_q == ST_DONE);

  // iteration tally, used only by the latency check
  logic [CNT_W-1:0] runs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     runs_q <= '0;
    else if (load_o) runs_q <= '0;
    else if (step_o) runs_q <= runs_q + ONE;
  end

  // R4
  iter_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> runs_q == K_V);

  // R5
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i && cnt_q > ONE) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) - ONE));

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (!ready_o && state_q == ST_RUN));
endmodule

// File: rtl/mont_pow2_reducer.sv
module mont_pow2_reducer #(
  parameter int DATA_W  = 16,
  parameter int MODULUS = 4093,
  parameter int SHIFT_K = 9,
  localparam int RES_W  = $clog2(MODULUS),
  localparam int OPW    = (DATA_W > RES_W) ? DATA_W : RES_W,
  localparam int ACC_W  = OPW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [RES_W-1:0]  result_o,
  output logic              ready_o
);
  logic             load, step, fix;
  logic [ACC_W-1:0] acc_q, acc_next;
  logic [RES_W-1:0] res_q, res_next;

  mont_seq_ctrl #(.SHIFT_K(SHIFT_K)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fix_o   (fix),
    .ready_o (ready_o)
  );

  mont_halve_step #(.ACC_W(ACC_W), .MODULUS(MODULUS)) i_step (
    .acc_i (acc_q),
    .acc_o (acc_next)
  );

  mont_final_sub #(.ACC_W(ACC_W), .RES_W(RES_W), .MODULUS(MODULUS)) i_fix (
    .acc_i (acc_q),
    .res_o (res_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (load) acc_q <= ACC_W'(y_i);
    else if (step) acc_q <= acc_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  res_q <= '0;
    else if (fix) res_q <= res_next;
  end

  assign result_o = res_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_q[ACC_W-1]);

  // R2
  reduced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ({1'b0, result_o} < (RES_W+1)'(MODULUS)));

  // R5
  result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(result_o));
endmodule

// File: tb/test_mont_pow2_reducer.sv
module test_mont_pow2_reducer;
  localparam int DATA_W  = 16;
  localparam int MODULUS = 4093;
  localparam int SHIFT_K = 9;
  localparam int RES_W   = $clog2(MODULUS);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] y_i = '0;
  logic [RES_W-1:0]  result_o;
  logic              ready_o;

  int checks = 0;
  int errors = 0;
  longint inv_k = 0;

  always #10 clk_i = ~clk_i;

  mont_pow2_reducer #(.DATA_W(DATA_W), .MODULUS(MODULUS), .SHIFT_K(SHIFT_K))
    i_mont_pow2_reducer (
      .clk_i, .rst_ni, .start_i, .y_i, .result_o, .ready_o);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint find_inv();
    for (longint c = 1; c < MODULUS; c++)
      if (((c << SHIFT_K) % MODULUS) == 1) return c;
    return 0;
  endfunction

  function automatic longint expect_res(longint y);
    return (y * inv_k) % MODULUS;
  endfunction

  // busy_at > 0 inserts a second start pulse that many cycles into the run
  task automatic run_op(longint y, int busy_at, string req);
    int lat;
    logic was_ready;
    was_ready = ready_o;
    @(negedge clk_i);
    y_i = DATA_W'(y);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    y_i = ~y_i;
    lat = 1;
    if (was_ready) chk("R7 ready drop on restart", longint'(ready_o), 0);
    while (!ready_o && lat < SHIFT_K + 12) begin
      if (lat == busy_at) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    chk({req, " latency"}, lat, SHIFT_K + 2);
    chk({req, " result"}, longint'(result_o), expect_res(y));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] held;
    void'($urandom(32'd5117));
    inv_k = find_inv();
    // R2 default inverse
    chk("R2 inverse of 2^k", inv_k, 1367);

    #25;
    chk("R1 ready in reset", longint'(ready_o), 0);
    chk("R1 result in reset", longint'(result_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 ready after reset", longint'(ready_o), 0);
    chk("R1 result after reset", longint'(result_o), 0);

    // R8 corner operands
    run_op(0, 0, "R8 zero");
    run_op(MODULUS, 0, "R8 y=m");
    run_op(MODULUS * 7, 0, "R8 y=7m");
    run_op(longint'(1) << SHIFT_K, 0, "R8 y=2^k");
    // R3 widest operands
    run_op((longint'(1) << DATA_W) - 1, 0, "R3 all ones");
    run_op((longint'(1) << DATA_W) - 2, 0, "R3 all ones minus one");
    run_op(MODULUS - 1, 0, "R2 y=m-1");
    run_op(1, 0, "R2 y=1");

    // R5 hold with input wiggling
    held = result_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      y_i = DATA_W'($urandom);
      chk("R5 ready held", longint'(ready_o), 1);
      chk("R5 result held", longint'(result_o), longint'(held));
    end

    // R6 start pulses mid-run at several points
    run_op(12345, 2, "R6 busy start early");
    run_op(54321, SHIFT_K, "R6 busy start late");
    run_op(40000, SHIFT_K + 1, "R6 busy start in fix");

    // R2 random operands
    for (int n = 0; n < 300; n++)
      run_op(longint'($urandom & 32'hFFFF), 0, "R2 random");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule